// File: doc/BRIEF.md
# Port Edge-Detect Interrupt Controller

This block watches an eight-pin input port. Software gives each pin a two-bit mode. A pin can be a plain input, a rising-edge detector, a falling-edge detector, or a direct interrupt request line. In either detect mode, an edge of the chosen polarity sets a sticky per-pin flag. Software clears that flag with a two-step handshake: it reads the flag register while the bit is set, then writes that bit as zero. Pins pass through a two-flop synchronizer. An edge is seen when the newest synchronized sample differs from the sample before it.

While any flag is set and the programmed level is nonzero, the block raises an interrupt request at that level. An acknowledge cycle names a level and carries a same-level-claimed input. Other sources that share the level use that input to take the cycle, so this block always loses to them. If the level matches and nobody claims the cycle, the block presents its programmed vector number for exactly one clock.

Each flag bit runs its own state machine: `FL_CLEAR` goes to `FL_SET` on a qualifying edge. `FL_SET` goes to `FL_ARMED` on a read of the flag register. `FL_ARMED` goes to `FL_CLEAR` on a write of zero to that bit, or back to `FL_SET` if a new edge arrives in the same cycle. The bit holds its state entirely while its pin is in plain or request mode. The request machine moves `IQ_IDLE` to `IQ_REQ` when the request is pending, and `IQ_REQ` back to `IQ_IDLE` when it is not. It moves `IQ_REQ` to `IQ_VECT` on a won acknowledge, and always leaves `IQ_VECT` after one cycle, to `IQ_REQ` or `IQ_IDLE`.

Top module: `edge_irq_port`

## Requirements
- R1: With pin mode 2'b01, a low-to-high change of the synchronized pin sets that pin's flag bit; a high-to-low change does not.
- R2: With pin mode 2'b10, a high-to-low change of the synchronized pin sets that pin's flag bit; a low-to-high change does not.
- R3: A set flag stays set, whatever the pin does, until a write to the flag register (address 1) clears it.
- R4: A write of zero clears a flag bit only if the flag register was read while that bit was set; writing one to a flag bit never clears it and does not remove the arming.
- R5: Arming is per bit: a bit that became set after the last flag read is not cleared by a following zero write.
- R6: In mode 2'b00 and mode 2'b11 a pin's flag bit keeps its state: edges do not set it and zero writes do not clear it.
- R7: After reset the mode register (address 0) reads 0, the flag register reads 0, the vector register (address 2) reads 8'h0F, the level register (address 3) reads 0, the request level output is 0 and no vector is presented.
- R8: While the level register holds 0 the request level output stays 0, even with flags set.
- R9: While any flag is set and the level register is nonzero, the request level output equals the level register from the next cycle on.
- R10: An unclaimed acknowledge whose level equals the active request level makes the vector output valid with the vector register's value for exactly one cycle, in the cycle after the acknowledge.
- R11: A claimed acknowledge, or one at a different level, produces no vector.
- R12: A pin in mode 2'b11 drives its bit of the external request output high while its synchronized input is low; pins in other modes drive 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Asynchronous port pins |
| bus_addr | input | 2 | Register select: 0 mode, 1 flags, 2 vector, 3 level |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing when address is 1) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register, combinational |
| irq_level_o | output | 3 | Active request level, 0 when idle |
| ext_irq_o | output | 8 | Per-pin direct request, for pins in request mode |
| iack_valid | input | 1 | Acknowledge cycle in progress |
| iack_level | input | 3 | Level being acknowledged |
| iack_claimed | input | 1 | Another same-level source takes this acknowledge |
| vec_valid | output | 1 | Vector output valid |
| vec_o | output | 8 | Vector number, 0 when not valid |

## Verification
The hardest situation to reach is a flag bit that sits in the armed state while its pin is switched into a frozen mode. A zero write must then do nothing. Once the edge-detect mode returns, the same bit must still clear with a zero write and no new read. The stimulus sets a flag, reads it to arm it, changes the mode, writes zero, and checks the flag through a read. It then restores the mode and writes zero again. Separately, per-bit arming is reached by letting a second pin's edge arrive between the read and the zero write.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    typedef enum logic [1:0] {
        PM_IO   = 2'b00,
        PM_RISE = 2'b01,
        PM_FALL = 2'b10,
        PM_IRQ  = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        FL_CLEAR = 2'd0,
        FL_SET   = 2'd1,
        FL_ARMED = 2'd2
    } flag_state_e;

    typedef enum logic [1:0] {
        IQ_IDLE = 2'd0,
        IQ_REQ  = 2'd1,
        IQ_VECT = 2'd2
    } irq_state_e;

    localparam logic [1:0] RA_MODE = 2'd0;
    localparam logic [1:0] RA_FLAG = 2'd1;
    localparam logic [1:0] RA_VEC  = 2'd2;
    localparam logic [1:0] RA_LVL  = 2'd3;

endpackage

// File: rtl/edge_sync_det.sv
module edge_sync_det #(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] pin_sync,
    output logic [NUM_PINS-1:0] rise,
    output logic [NUM_PINS-1:0] fall
);
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        // stages [0..SYNC_STAGES-1] synchronize, last stage holds previous sample
        logic [SYNC_STAGES:0] sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[SYNC_STAGES-1:0], pin_i[g]};
        end
        assign pin_sync[g] = sh[SYNC_STAGES-1];
        assign rise[g]     = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
        assign fall[g]     = ~sh[SYNC_STAGES-1] & sh[SYNC_STAGES];
    end
endmodule

// File: rtl/flag_cell.sv
module flag_cell
    import edge_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pin_mode_e mode,
    input  logic      rise,
    input  logic      fall,
    input  logic      rd_hit,
    input  logic      wr_hit,
    input  logic      wr_bit,
    output logic      flag
);
    flag_state_e state_q, state_d;
    logic frozen, hit;

    assign frozen = (mode == PM_IO) || (mode == PM_IRQ);
    assign hit    = ((mode == PM_RISE) && rise) || ((mode == PM_FALL) && fall);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!frozen) begin
            unique case (state_q)
                FL_CLEAR: if (hit) state_d = FL_SET;
                FL_SET:   if (rd_hit) state_d = FL_ARMED;
                FL_ARMED: if (wr_hit && !wr_bit) state_d = hit ? FL_SET : FL_CLEAR;
                default:  state_d = FL_CLEAR;
            endcase
        end
    end

    always_comb begin
        flag = (state_q != FL_CLEAR);
    end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import edge_irq_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_flag,
    input  logic [LVL_W-1:0] level_q,
    input  logic [VEC_W-1:0] vec_q,
    input  logic             iack_valid,
    input  logic [LVL_W-1:0] iack_level,
    input  logic             iack_claimed,
    output logic [LVL_W-1:0] irq_level_o,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_o
);
    irq_state_e state_q, state_d;
    logic pending, win;

    assign pending = any_flag && (level_q != '0);
    assign win     = iack_valid && !iack_claimed && (iack_level == level_q) && (level_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IQ_IDLE: if (pending) state_d = IQ_REQ;
            IQ_REQ:  begin
                if (win)           state_d = IQ_VECT;
                else if (!pending) state_d = IQ_IDLE;
            end
            IQ_VECT: state_d = pending ? IQ_REQ : IQ_IDLE;
            default: state_d = IQ_IDLE;
        endcase
    end

    always_comb begin
        irq_level_o = (state_q == IQ_IDLE) ? '0 : level_q;
        vec_valid   = (state_q == IQ_VECT);
        vec_o       = (state_q == IQ_VECT) ? vec_q : '0;
    end
endmodule

// File: rtl/edge_irq_port.sv
module edge_irq_port
    import edge_irq_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int LVL_W       = 3,
    parameter int VEC_W       = 8,
    parameter logic [VEC_W-1:0] VEC_RESET = 8'h0F
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_i,
    input  logic [1:0]            bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [2*NUM_PINS-1:0] bus_wdata,
    output logic [2*NUM_PINS-1:0] bus_rdata,
    output logic [LVL_W-1:0]      irq_level_o,
    output logic [NUM_PINS-1:0]   ext_irq_o,
    input  logic                  iack_valid,
    input  logic [LVL_W-1:0]      iack_level,
    input  logic                  iack_claimed,
    output logic                  vec_valid,
    output logic [VEC_W-1:0]      vec_o
);
    localparam int BUS_W = 2 * NUM_PINS;

    logic [BUS_W-1:0]    mode_q;
    logic [VEC_W-1:0]    vec_q;
    logic [LVL_W-1:0]    level_q;
    logic [NUM_PINS-1:0] pin_sync, rise, fall, flags;
    logic                rd_flag, wr_flag;

    assign rd_flag = bus_rd && (bus_addr == RA_FLAG);
    assign wr_flag = bus_wr && (bus_addr == RA_FLAG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            vec_q   <= VEC_RESET;
            level_q <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                RA_MODE: mode_q  <= bus_wdata;
                RA_VEC:  vec_q   <= bus_wdata[VEC_W-1:0];
                RA_LVL:  level_q <= bus_wdata[LVL_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (bus_addr)
            RA_MODE: bus_rdata = mode_q;
            RA_FLAG: bus_rdata = BUS_W'(flags);
            RA_VEC:  bus_rdata = BUS_W'(vec_q);
            default: bus_rdata = BUS_W'(level_q);
        endcase
    end

    edge_sync_det #(
        .NUM_PINS    (NUM_PINS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (pin_i),
        .pin_sync (pin_sync),
        .rise     (rise),
        .fall     (fall)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_flag
        pin_mode_e pmode;
        assign pmode = pin_mode_e'(mode_q[2*g +: 2]);
        assign ext_irq_o[g] = (pmode == PM_IRQ) && !pin_sync[g];

        flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (pmode),
            .rise   (rise[g]),
            .fall   (fall[g]),
            .rd_hit (rd_flag),
            .wr_hit (wr_flag),
            .wr_bit (bus_wdata[g]),
            .flag   (flags[g])
        );
    end

    irq_ack_fsm #(
        .LVL_W (LVL_W),
        .VEC_W (VEC_W)
    ) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .any_flag     (|flags),
        .level_q      (level_q),
        .vec_q        (vec_q),
        .iack_valid   (iack_valid),
        .iack_level   (iack_level),
        .iack_claimed (iack_claimed),
        .irq_level_o  (irq_level_o),
        .vec_valid    (vec_valid),
        .vec_o        (vec_o)
    );
endmodule

// File: rtl/edge_irq_port_chk.sv
module edge_irq_port_chk #(
    parameter int NUM_PINS = 8,
    parameter int LVL_W    = 3,
    parameter int VEC_W    = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            bus_addr,
    input logic                  bus_wr,
    input logic [2*NUM_PINS-1:0] bus_wdata,
    input logic [2*NUM_PINS-1:0] mode_q,
    input logic [NUM_PINS-1:0]   flags,
    input logic [LVL_W-1:0]      level_q,
    input logic [VEC_W-1:0]      vec_q,
    input logic [LVL_W-1:0]      irq_level_o,
    input logic [NUM_PINS-1:0]   ext_irq_o,
    input logic                  iack_valid,
    input logic [LVL_W-1:0]      iack_level,
    input logic                  iack_claimed,
    input logic                  vec_valid,
    input logic [VEC_W-1:0]      vec_o
);
    logic [NUM_PINS-1:0] frz, irqm;
    logic wr_flag, wr_lvl;

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            frz[i]  = (mode_q[2*i +: 2] == 2'b00) || (mode_q[2*i +: 2] == 2'b11);
            irqm[i] = (mode_q[2*i +: 2] == 2'b11);
        end
    end
    assign wr_flag = bus_wr && (bus_addr == 2'd1);
    assign wr_lvl  = bus_wr && (bus_addr == 2'd3);

    p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_flag |=> ((flags & $past(flags)) == $past(flags)));

    p_ones_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flag |=> ((~flags & $past(flags) & $past(bus_wdata[NUM_PINS-1:0])) == '0));

    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (((flags ^ $past(flags)) & $past(frz)) == '0));

    p_zero_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q == '0) |-> (irq_level_o == '0));

    p_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|flags) && (level_q != '0) && !wr_lvl) |=> (irq_level_o == $past(level_q)));

    p_vec_win_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_valid && !iack_claimed && (irq_level_o != '0) && (iack_level == irq_level_o) && !vec_valid)
        |=> (vec_valid && (vec_o == vec_q)));

    p_vec_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    p_claim_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!iack_valid || iack_claimed) |=> !vec_valid);

    p_ext_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((ext_irq_o & ~irqm) == '0));
endmodule

bind edge_irq_port edge_irq_port_chk #(
    .NUM_PINS (NUM_PINS),
    .LVL_W    (LVL_W),
    .VEC_W    (VEC_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .mode_q       (mode_q),
    .flags        (flags),
    .level_q      (level_q),
    .vec_q        (vec_q),
    .irq_level_o  (irq_level_o),
    .ext_irq_o    (ext_irq_o),
    .iack_valid   (iack_valid),
    .iack_level   (iack_level),
    .iack_claimed (iack_claimed),
    .vec_valid    (vec_valid),
    .vec_o        (vec_o)
);

// File: tb/edge_irq_port_bench.sv
`timescale 1ns/1ps
module edge_irq_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_i = '0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  irq_level_o;
    logic [7:0]  ext_irq_o;
    logic        iack_valid = 1'b0;
    logic [2:0]  iack_level = '0;
    logic        iack_claimed = 1'b0;
    logic        vec_valid;
    logic [7:0]  vec_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    edge_irq_port u_edge_irq_port (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_level_o(irq_level_o), .ext_irq_o(ext_irq_o),
        .iack_valid(iack_valid), .iack_level(iack_level), .iack_claimed(iack_claimed),
        .vec_valid(vec_valid), .vec_o(vec_o)
    );

    typedef struct packed {
        logic [15:0] mode;
        logic [7:0]  start;
        logic [7:0]  fin;
        logic [7:0]  exp;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{16'h5555, 8'h00, 8'hFF, 8'hFF},
        '{16'h5555, 8'hFF, 8'h00, 8'h00},
        '{16'hAAAA, 8'hFF, 8'h00, 8'hFF},
        '{16'hAAAA, 8'h00, 8'hFF, 8'h00},
        '{16'h0000, 8'h00, 8'hFF, 8'h00},
        '{16'hFFFF, 8'hFF, 8'h00, 8'h00},
        '{16'hE4E4, 8'h0F, 8'hF0, 8'h24},
        '{16'hE4E4, 8'h55, 8'hAA, 8'h66}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic ack(input logic [2:0] lvl, input logic claim, output logic v, output logic [7:0] vv);
        @(negedge clk);
        iack_valid = 1'b1; iack_level = lvl; iack_claimed = claim;
        @(posedge clk); #1;
        v = vec_valid; vv = vec_o;
        @(negedge clk);
        iack_valid = 1'b0; iack_claimed = 1'b0;
    endtask

    initial begin
        cyc(50000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic        v;
        logic [7:0]  vv;
        cyc(3);
        @(negedge clk) rst_n = 1'b1;
        cyc(2);

        // R7 reset state
        rd(2'd0, d); check("R7 mode reset", d, 16'h0000);
        rd(2'd1, d); check("R7 flag reset", d, 16'h0000);
        rd(2'd2, d); check("R7 vector reset", d, 16'h000F);
        rd(2'd3, d); check("R7 level reset", d, 16'h0000);
        check("R7 irq level reset", {13'd0, irq_level_o}, 16'd0);
        check("R7 vec valid reset", {15'd0, vec_valid}, 16'd0);

        // table: R1 R2 R6 edge qualification per mode
        foreach (TBL[k]) begin
            wr(2'd0, 16'h5555);
            pin_i = TBL[k].start;
            cyc(5);
            rd(2'd1, d);
            wr(2'd1, 16'h0000);
            wr(2'd0, TBL[k].mode);
            cyc(2);
            pin_i = TBL[k].fin;
            cyc(6);
            rd(2'd1, d);
            check($sformatf("R1/R2/R6 table entry %0d", k), d, {8'd0, TBL[k].exp});
        end

        // clean state, all rising mode, pins low
        wr(2'd0, 16'h5555);
        pin_i = 8'h00;
        cyc(5);
        rd(2'd1, d);
        wr(2'd1, 16'h0000);
        rd(2'd1, d); check("R4 cleanup clear", d, 16'h0000);

        // R3 sticky, R4 no clear without read
        pin_i = 8'h01; cyc(6);
        pin_i = 8'h00; cyc(6);
        wr(2'd1, 16'h0000);
        rd(2'd1, d); check("R3 sticky after pin returns, R4 unarmed zero write", d, 16'h0001);
        wr(2'd1, 16'h00FF);
        rd(2'd1, d); check("R4 write one ignored", d, 16'h0001);
        wr(2'd1, 16'h0000);
        rd(2'd1, d); check("R4 armed zero write clears", d, 16'h0000);

        // R5 per-bit arming
        pin_i = 8'h01; cyc(6);
        rd(2'd1, d); check("R5 bit0 set", d, 16'h0001);
        pin_i = 8'h03; cyc(6);
        wr(2'd1, 16'h0000);
        rd(2'd1, d); check("R5 late bit stays", d, 16'h0002);

        // R6 frozen mode holds an armed bit
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0000);
        rd(2'd1, d); check("R6 zero write ignored in io mode", d, 16'h0002);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'h0000);
        rd(2'd1, d); check("R6 arming kept across frozen mode", d, 16'h0000);

        // R8 level zero, R9 request
        pin_i = 8'h00; cyc(6);
        pin_i = 8'h01; cyc(6);
        check("R8 level zero disables", {13'd0, irq_level_o}, 16'd0);
        wr(2'd2, 16'h0042);
        wr(2'd3, 16'h0005);
        cyc(3);
        check("R9 request at level", {13'd0, irq_level_o}, 16'd5);

        // R10 won acknowledge
        ack(3'd5, 1'b0, v, vv);
        check("R10 vector valid", {15'd0, v}, 16'd1);
        check("R10 vector value", {8'd0, vv}, 16'h0042);
        @(posedge clk); #1;
        check("R10 single cycle", {15'd0, vec_valid}, 16'd0);

        // R11 claimed and mismatched
        ack(3'd5, 1'b1, v, vv);
        check("R11 claimed no vector", {15'd0, v}, 16'd0);
        ack(3'd3, 1'b0, v, vv);
        check("R11 wrong level no vector", {15'd0, v}, 16'd0);

        // R9 release
        rd(2'd1, d);
        wr(2'd1, 16'h0000);
        cyc(3);
        check("R9 request drops with flags", {13'd0, irq_level_o}, 16'd0);

        // R12 direct request mode
        wr(2'd0, 16'h0003);
        pin_i = 8'h00; cyc(4);
        #1 check("R12 low pin requests", {8'd0, ext_irq_o}, 16'h0001);
        pin_i = 8'h01; cyc(4);
        #1 check("R12 high pin idle", {8'd0, ext_irq_o}, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule